// File: doc/BRIEF.md
# Host Command Vector Sequencer

This block raises one command interrupt toward a signal processor that sits behind a byte-wide host port, then waits until the processor accepts it. A command is given as a descriptor: a 7-bit vector, two host-flag request bits (HF0, HF1), a bit that skips the flag-register update, a bit that turns on a mailbox handshake on flag HF5, and two selectors for fixed waits after the vector is posted. A single `start` pulse begins the sequence. The block ends it with a one-cycle `done` pulse, or with an `err` pulse that tells which poll timed out.

The host port is modelled as a read/write strobe pair with a 2-bit target select: 0 = interface control register (ICR), 1 = command vector register (CVR), 2 = 32-bit mailbox register. Read data is combinational and is sampled in the same cycle as the read strobe. Waits and timeouts count in milliseconds. A millisecond lasts `TICKS_PER_MS` clock cycles, so a bench can make it short.

The controller moves through these states. S_IDLE goes to S_MBX_RD on a start with HF5 handshake, to S_ICR_WR on a start without skip, and to S_CVR_WR otherwise. S_MBX_RD always goes to S_MBX_WR. S_MBX_WR goes to S_ICR_WR, or to S_CVR_WR when skip is set. S_ICR_WR goes to S_CVR_WR. S_CVR_WR always goes to S_DELAY. S_DELAY goes to S_CVR_POLL once the wait has expired. S_CVR_POLL goes to S_HF5_POLL or S_FINISH when the pending bit clears, and to S_FINISH with an error on timeout. S_HF5_POLL goes to S_FINISH when the flag is set, or on timeout. S_FINISH always goes to S_IDLE.

Top module: `hcv_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `err_hf5` are low and neither `bus_rd` nor `bus_wr` is asserted. The bus stays quiet whenever the block is not busy.
- R2: `start` is accepted only when the block is idle, and the next cycle then shows `busy` high. A `start` pulse while busy has no effect: no extra bus writes and no extra `done`.
- R3: With the HF5 handshake selected, the first bus accesses are a mailbox read (select 2) followed by a mailbox write of the same word with bit 0 cleared and all other bits kept.
- R4: Unless skip is set, one ICR write (select 0) carries 0x07, ORed with 0x08 when HF0 is requested and with 0x10 when HF1 is requested. With skip set, no ICR write occurs.
- R5: Exactly one CVR write (select 1) occurs, with data 0x80 | vector. For example, vector 0x3A gives 0xBA. It comes after any mailbox and ICR writes.
- R6: The wait after the CVR write is 25 ms for the short selector, 65 ms for the long one, 90 ms with both and 0 with neither. The first CVR poll read comes exactly W*TICKS_PER_MS + 2 cycles after the CVR write cycle.
- R7: The CVR is read every cycle until its bit 7 reads 0. Without the HF5 handshake, `done` follows one cycle later.
- R8: With the HF5 handshake, after bit 7 of the CVR clears, the mailbox is read every cycle until bit 0 reads 1. `done` follows one cycle later.
- R9: A poll that lasts 200 ms (TIMEOUT_MS) ends with an `err` pulse. `err_hf5` is 0 when the CVR poll timed out and 1 when the HF5 poll timed out.
- R10: `done` and `err` are single-cycle pulses and never occur together. `busy` stays high from acceptance until the cycle of that pulse, in which it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted when idle) |
| cmd_vector | input | 7 | Command vector placed in CVR bits 6:0 |
| cmd_hf0 | input | 1 | Request HF0 in the ICR write |
| cmd_hf1 | input | 1 | Request HF1 in the ICR write |
| cmd_skip_flags | input | 1 | Skip the ICR write |
| cmd_manage_hf5 | input | 1 | Clear HF5 first, wait for it after the CVR poll |
| cmd_wait_short | input | 1 | Add a 25 ms wait after the CVR write |
| cmd_wait_long | input | 1 | Add a 65 ms wait after the CVR write |
| bus_rd | output | 1 | Host port read strobe |
| bus_wr | output | 1 | Host port write strobe |
| bus_sel | output | 2 | Target: 0 ICR, 1 CVR, 2 mailbox |
| bus_wdata | output | 32 | Write data (byte registers use bits 7:0) |
| bus_rdata | input | 32 | Read data, valid in the cycle of `bus_rd` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle timeout pulse |
| err_hf5 | output | 1 | With `err`: 1 = HF5 poll timed out, 0 = CVR poll |

## Verification
The hardest paths to reach are the two timeouts. Each needs a poll that never succeeds for 200 ms of ticks, and the HF5 timeout also needs the CVR poll to succeed first. The bench's processor model acknowledges the CVR after a chosen latency and sets HF5 after a second chosen latency. Either can be set to "never", which steers the sequencer into one timeout or the other. A short `TICKS_PER_MS` keeps these runs brief, and the same model's cycle stamps give the exact length of each post-write wait.

// File: rtl/hcv_pkg.sv
package hcv_pkg;

    typedef enum logic [1:0] {
        PORT_ICR  = 2'd0,
        PORT_CVR  = 2'd1,
        PORT_MBOX = 2'd2
    } port_sel_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MBX_RD,
        S_MBX_WR,
        S_ICR_WR,
        S_CVR_WR,
        S_DELAY,
        S_CVR_POLL,
        S_HF5_POLL,
        S_FINISH
    } seq_state_e;

    localparam logic [7:0] ICR_BASE    = 8'h07;
    localparam logic [7:0] ICR_HF0     = 8'h08;
    localparam logic [7:0] ICR_HF1     = 8'h10;
    localparam logic [7:0] CVR_PENDING = 8'h80;

endpackage

// File: rtl/hcv_ms_timer.sv
module hcv_ms_timer #(
    parameter int TICKS_PER_MS = 100000,
    parameter int MS_W         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [MS_W-1:0] ms_count
);
    localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

    logic [PW-1:0] presc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q  <= '0;
            ms_count <= '0;
        end else if (clr) begin
            presc_q  <= '0;
            ms_count <= '0;
        end else if (presc_q == LAST) begin
            presc_q  <= '0;
            ms_count <= ms_count + 1'b1;
        end else begin
            presc_q  <= presc_q + 1'b1;
        end
    end
endmodule

// File: rtl/hcv_word_builder.sv
module hcv_word_builder
    import hcv_pkg::*;
#(
    parameter int SHORT_WAIT_MS = 25,
    parameter int LONG_WAIT_MS  = 65,
    parameter int MS_W          = 8
) (
    input  logic [6:0]      vector,
    input  logic            hf0,
    input  logic            hf1,
    input  logic            wait_short,
    input  logic            wait_long,
    input  logic [31:0]     mbox_word,
    output logic [7:0]      icr_byte,
    output logic [7:0]      cvr_byte,
    output logic [31:0]     mbox_clr_word,
    output logic [MS_W-1:0] wait_ms
);
    always_comb begin
        icr_byte = ICR_BASE | (hf0 ? ICR_HF0 : 8'h00) | (hf1 ? ICR_HF1 : 8'h00);
        cvr_byte = CVR_PENDING | {1'b0, vector};
        mbox_clr_word = mbox_word & ~32'h1;
        wait_ms = (wait_short ? MS_W'(SHORT_WAIT_MS) : '0)
                + (wait_long  ? MS_W'(LONG_WAIT_MS)  : '0);
    end
endmodule

// File: rtl/hcv_sequencer.sv
module hcv_sequencer
    import hcv_pkg::*;
#(
    parameter int TICKS_PER_MS  = 100000,
    parameter int SHORT_WAIT_MS = 25,
    parameter int LONG_WAIT_MS  = 65,
    parameter int TIMEOUT_MS    = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [6:0]  cmd_vector,
    input  logic        cmd_hf0,
    input  logic        cmd_hf1,
    input  logic        cmd_skip_flags,
    input  logic        cmd_manage_hf5,
    input  logic        cmd_wait_short,
    input  logic        cmd_wait_long,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [1:0]  bus_sel,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        err_hf5
);
    localparam int WAIT_SUM = SHORT_WAIT_MS + LONG_WAIT_MS;
    localparam int MS_MAX   = ((WAIT_SUM > TIMEOUT_MS) ? WAIT_SUM : TIMEOUT_MS) + 1;
    localparam int MS_W     = $clog2(MS_MAX + 1);
    localparam logic [MS_W-1:0] TIMEOUT_LIM = MS_W'(TIMEOUT_MS);

    seq_state_e state_q, state_d;

    logic [6:0]  vec_q;
    logic        hf0_q, hf1_q, skip_q, hf5_q, wshort_q, wlong_q;
    logic [31:0] mbox_q;
    logic        fail_q, fail_hf5_q;
    logic        fail_set, fail_hf5_set;

    logic [7:0]      icr_byte, cvr_byte;
    logic [31:0]     mbox_clr_word;
    logic [MS_W-1:0] wait_ms, ms_count;
    logic            tmr_clr, timed;

    hcv_word_builder #(
        .SHORT_WAIT_MS(SHORT_WAIT_MS),
        .LONG_WAIT_MS (LONG_WAIT_MS),
        .MS_W         (MS_W)
    ) u_words (
        .vector       (vec_q),
        .hf0          (hf0_q),
        .hf1          (hf1_q),
        .wait_short   (wshort_q),
        .wait_long    (wlong_q),
        .mbox_word    (mbox_q),
        .icr_byte     (icr_byte),
        .cvr_byte     (cvr_byte),
        .mbox_clr_word(mbox_clr_word),
        .wait_ms      (wait_ms)
    );

    hcv_ms_timer #(
        .TICKS_PER_MS(TICKS_PER_MS),
        .MS_W        (MS_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .ms_count(ms_count)
    );

    // State register and captured descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            vec_q      <= '0;
            hf0_q      <= 1'b0;
            hf1_q      <= 1'b0;
            skip_q     <= 1'b0;
            hf5_q      <= 1'b0;
            wshort_q   <= 1'b0;
            wlong_q    <= 1'b0;
            mbox_q     <= '0;
            fail_q     <= 1'b0;
            fail_hf5_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                vec_q      <= cmd_vector;
                hf0_q      <= cmd_hf0;
                hf1_q      <= cmd_hf1;
                skip_q     <= cmd_skip_flags;
                hf5_q      <= cmd_manage_hf5;
                wshort_q   <= cmd_wait_short;
                wlong_q    <= cmd_wait_long;
                fail_q     <= 1'b0;
                fail_hf5_q <= 1'b0;
            end
            if (state_q == S_MBX_RD) mbox_q <= bus_rdata;
            if (fail_set) begin
                fail_q     <= 1'b1;
                fail_hf5_q <= fail_hf5_set;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d      = state_q;
        bus_rd       = 1'b0;
        bus_wr       = 1'b0;
        bus_sel      = PORT_ICR;
        bus_wdata    = '0;
        fail_set     = 1'b0;
        fail_hf5_set = 1'b0;
        timed        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (cmd_manage_hf5)      state_d = S_MBX_RD;
                    else if (cmd_skip_flags) state_d = S_CVR_WR;
                    else                     state_d = S_ICR_WR;
                end
            end
            S_MBX_RD: begin
                bus_rd  = 1'b1;
                bus_sel = PORT_MBOX;
                state_d = S_MBX_WR;
            end
            S_MBX_WR: begin
                bus_wr    = 1'b1;
                bus_sel   = PORT_MBOX;
                bus_wdata = mbox_clr_word;
                state_d   = skip_q ? S_CVR_WR : S_ICR_WR;
            end
            S_ICR_WR: begin
                bus_wr    = 1'b1;
                bus_sel   = PORT_ICR;
                bus_wdata = {24'h0, icr_byte};
                state_d   = S_CVR_WR;
            end
            S_CVR_WR: begin
                bus_wr    = 1'b1;
                bus_sel   = PORT_CVR;
                bus_wdata = {24'h0, cvr_byte};
                state_d   = S_DELAY;
            end
            S_DELAY: begin
                timed = 1'b1;
                if (ms_count == wait_ms) state_d = S_CVR_POLL;
            end
            S_CVR_POLL: begin
                timed   = 1'b1;
                bus_rd  = 1'b1;
                bus_sel = PORT_CVR;
                if (!bus_rdata[7]) begin
                    state_d = hf5_q ? S_HF5_POLL : S_FINISH;
                end else if (ms_count == TIMEOUT_LIM) begin
                    state_d  = S_FINISH;
                    fail_set = 1'b1;
                end
            end
            S_HF5_POLL: begin
                timed   = 1'b1;
                bus_rd  = 1'b1;
                bus_sel = PORT_MBOX;
                if (bus_rdata[0]) begin
                    state_d = S_FINISH;
                end else if (ms_count == TIMEOUT_LIM) begin
                    state_d      = S_FINISH;
                    fail_set     = 1'b1;
                    fail_hf5_set = 1'b1;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        tmr_clr = !timed || (state_d != state_q);
        busy    = (state_q != S_IDLE) && (state_q != S_FINISH);
        done    = (state_q == S_FINISH) && !fail_q;
        err     = (state_q == S_FINISH) && fail_q;
        err_hf5 = (state_q == S_FINISH) && fail_q && fail_hf5_q;
    end
endmodule

// File: rtl/hcv_sequencer_chk.sv
module hcv_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [1:0]  bus_sel,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        err_hf5
);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !err && start) |=> busy);

    assert_mbox_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2) |-> (bus_wdata == ($past(bus_rdata) & ~32'h1)));

    assert_icr_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd0) |-> (bus_wdata[2:0] == 3'b111 && bus_wdata[31:5] == '0));

    assert_cvr_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd1) |-> (bus_wdata[7] && bus_wdata[31:8] == '0));

    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_err_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_hf5 |-> err);

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));
endmodule

bind hcv_sequencer hcv_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_sel  (bus_sel),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .err_hf5  (err_hf5)
);

// File: tb/hcv_sequencer_bench.sv
module hcv_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPM        = 4;
    localparam int TMO        = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  cmd_vector = '0;
    logic        cmd_hf0 = 1'b0, cmd_hf1 = 1'b0, cmd_skip_flags = 1'b0;
    logic        cmd_manage_hf5 = 1'b0, cmd_wait_short = 1'b0, cmd_wait_long = 1'b0;
    logic        bus_rd, bus_wr;
    logic [1:0]  bus_sel;
    logic [31:0] bus_wdata, bus_rdata;
    logic        busy, done, err, err_hf5;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcv_sequencer #(.TICKS_PER_MS(TPM), .TIMEOUT_MS(TMO)) u_hcv_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_vector(cmd_vector),
        .cmd_hf0(cmd_hf0), .cmd_hf1(cmd_hf1), .cmd_skip_flags(cmd_skip_flags),
        .cmd_manage_hf5(cmd_manage_hf5), .cmd_wait_short(cmd_wait_short),
        .cmd_wait_long(cmd_wait_long), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .err(err), .err_hf5(err_hf5)
    );

    // Processor model
    logic [7:0]  m_icr = '0, m_cvr = '0;
    logic [31:0] m_mbox = '0;
    int          ack_cnt = -1, hf5_cnt = -1;
    int          m_ack_lat = 1, m_hf5_lat = 1;
    logic        mb_load = 1'b0, log_clr = 1'b0;
    logic [31:0] mb_load_val = '0;
    logic [1:0]  log_sel [8];
    logic [31:0] log_dat [8];
    int          nlog = 0, cyc = 0, c_wr = 0, c_rd = 0;
    logic        seen_rd = 1'b0;

    assign bus_rdata = (bus_sel == 2'd1) ? {24'h0, m_cvr} :
                       (bus_sel == 2'd2) ? m_mbox : {24'h0, m_icr};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mb_load) begin
            m_mbox  <= mb_load_val;
            m_cvr   <= '0;
            ack_cnt <= -1;
            hf5_cnt <= -1;
        end else if (bus_wr) begin
            case (bus_sel)
                2'd0: m_icr <= bus_wdata[7:0];
                2'd1: begin
                    m_cvr <= bus_wdata[7:0];
                    if (bus_wdata[7]) ack_cnt <= m_ack_lat;
                end
                default: m_mbox <= bus_wdata;
            endcase
        end else begin
            if (ack_cnt > 0) ack_cnt <= ack_cnt - 1;
            else if (ack_cnt == 0) begin
                m_cvr[7] <= 1'b0;
                ack_cnt  <= -1;
                if (m_hf5_lat >= 0) hf5_cnt <= m_hf5_lat;
            end
            if (hf5_cnt > 0) hf5_cnt <= hf5_cnt - 1;
            else if (hf5_cnt == 0) begin
                m_mbox[0] <= 1'b1;
                hf5_cnt   <= -1;
            end
        end
        if (log_clr) begin
            nlog    <= 0;
            seen_rd <= 1'b0;
        end else begin
            if (bus_wr && nlog < 8) begin
                log_sel[nlog] <= bus_sel;
                log_dat[nlog] <= bus_wdata;
                nlog <= nlog + 1;
            end
            if (bus_wr && bus_sel == 2'd1) c_wr <= cyc;
            if (bus_rd && bus_sel == 2'd1 && !seen_rd) begin
                c_rd    <= cyc;
                seen_rd <= 1'b1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    logic r_done, r_err, r_hf5, r_busy_hole, r_after_bad;

    task automatic run_cmd(input logic [6:0] v, input logic h0, input logic h1,
                           input logic sk, input logic mh, input logic ws, input logic wl,
                           input int ack, input int hfl, input logic [31:0] mb,
                           input int glitch_at);
        @(negedge clk);
        m_ack_lat = ack; m_hf5_lat = hfl;
        mb_load_val = mb; mb_load = 1'b1; log_clr = 1'b1;
        @(negedge clk);
        mb_load = 1'b0; log_clr = 1'b0;
        cmd_vector = v; cmd_hf0 = h0; cmd_hf1 = h1; cmd_skip_flags = sk;
        cmd_manage_hf5 = mh; cmd_wait_short = ws; cmd_wait_long = wl;
        start = 1'b1;
        r_busy_hole = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            start = (n == glitch_at);
            if (n == glitch_at) begin
                cmd_vector = 7'h11; cmd_skip_flags = 1'b0;
            end
            if (done || err) break;
            if (!busy) r_busy_hole = 1'b1;
        end
        start = 1'b0;
        r_done = done; r_err = err; r_hf5 = err_hf5;
        chk(!busy, "R10 busy low at pulse", busy, 0);
        @(negedge clk);
        r_after_bad = done || err || busy;
    endtask

    task automatic expect_log(input int idx, input logic [1:0] s, input logic [31:0] d, input string req);
        chk(log_sel[idx] == s && log_dat[idx] == d, req, {log_sel[idx], log_dat[idx]}, {s, d});
    endtask

    task automatic t_reset;
        chk(!busy && !done && !err && !err_hf5, "R1 reset outputs", {busy, done, err, err_hf5}, 0);
        chk(!bus_rd && !bus_wr, "R1 reset bus idle", {bus_rd, bus_wr}, 0);
    endtask

    task automatic t_message;
        run_cmd(7'h3A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5, -1, 32'h0, -1);
        chk(r_done && !r_err, "R7 message done", {r_done, r_err}, 2'b10);
        chk(nlog == 1, "R4 skip gives no ICR write", nlog, 1);
        expect_log(0, 2'd1, 32'hBA, "R5 CVR byte");
        chk(c_rd - c_wr == 2, "R6 zero wait", c_rd - c_wr, 2);
        chk(!r_busy_hole && !r_after_bad, "R10 busy and single pulse", {r_busy_hole, r_after_bad}, 0);
    endtask

    task automatic t_boot;
        run_cmd(7'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3, 7, 32'hABCD0003, -1);
        chk(r_done && !r_err, "R8 boot done after HF5", {r_done, r_err}, 2'b10);
        chk(nlog == 3, "R3 write count", nlog, 3);
        expect_log(0, 2'd2, 32'hABCD0002, "R3 mailbox cleared");
        expect_log(1, 2'd0, 32'h17, "R4 ICR with HF1");
        expect_log(2, 2'd1, 32'h86, "R5 CVR after ICR");
        chk(c_rd - c_wr == 25*TPM + 2, "R6 short wait", c_rd - c_wr, 25*TPM + 2);
    endtask

    task automatic t_reset_board;
        run_cmd(7'h06, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2, 2, 32'h1, -1);
        chk(r_done, "R8 long-wait done", r_done, 1);
        expect_log(0, 2'd2, 32'h0, "R3 mailbox bit0 cleared");
        expect_log(1, 2'd0, 32'h0F, "R4 ICR with HF0");
        chk(c_rd - c_wr == 65*TPM + 2, "R6 long wait", c_rd - c_wr, 65*TPM + 2);
    endtask

    task automatic t_both_waits;
        run_cmd(7'h2E, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1, -1, 32'h0, -1);
        chk(r_done && nlog == 1, "R4 skip ignores flags", nlog, 1);
        expect_log(0, 2'd1, 32'hAE, "R5 semaphore CVR");
        chk(c_rd - c_wr == 90*TPM + 2, "R6 both waits", c_rd - c_wr, 90*TPM + 2);
    endtask

    task automatic t_cvr_timeout;
        run_cmd(7'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1000000, 1, 32'h0, -1);
        chk(r_err && !r_done && !r_hf5, "R9 CVR timeout", {r_err, r_done, r_hf5}, 3'b100);
        chk(!r_after_bad, "R10 err single pulse", r_after_bad, 0);
    endtask

    task automatic t_hf5_timeout;
        run_cmd(7'h02, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2, -1, 32'h0, -1);
        chk(r_err && !r_done && r_hf5, "R9 HF5 timeout", {r_err, r_done, r_hf5}, 3'b101);
    endtask

    task automatic t_busy_start;
        run_cmd(7'h3A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40, -1, 32'h0, 10);
        chk(r_done && nlog == 1, "R2 start while busy ignored", nlog, 1);
        expect_log(0, 2'd1, 32'hBA, "R2 first descriptor kept");
        repeat (20) @(negedge clk);
        chk(nlog == 1 && !busy, "R2 no later activity", nlog, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_message();
        t_boot();
        t_reset_board();
        t_both_waits();
        t_cvr_timeout();
        t_hf5_timeout();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule